// File: doc/BRIEF.md
# Multi-Warp SIMT Issue Scheduler

This block holds the control state of several resident warps, each a group of lanes that run in lock-step. It issues one instruction per cycle from a warp that is eligible to run. Each warp keeps its own program counter, its own active-lane mask and a small reconvergence stack. A warp that waits on a memory load is skipped, and another warp issues in its place. Each warp has private state, so switching warps costs no cycles.

Instructions come from a combinational supply port. The block drives a warp id and a PC, and the supply returns the instruction word together with a per-lane condition vector for that instruction. Load/store instructions have fewer execution units than there are lanes, so they go out in several dispatch turns over consecutive issue handshakes, one lane slice per turn. After its last turn the warp sleeps until a completion pulse names it.

The issue port is valid/ready. A beat transfers only when `iss_valid` and `iss_ready` are both high. While `iss_valid` is high and `iss_ready` is low, the warp id, instruction, mask and turn do not change. `iss_valid` does not drop before the transfer completes. The memory-completion input has no back-pressure: every pulse is accepted.

Top module: `simt_issue_sched`

## Requirements
- R1: After reset every warp is active at PC 0 with all lanes enabled. The first beat offered comes from warp 0 with the full lane mask.
- R2: When no dispatch turn sequence is in progress, the issuing warp is the first eligible warp found searching upward, wrapping, from the warp after the one that issued the last beat. Warp 0 is searched first after reset.
- R3: Each warp's instructions are issued in program order of its own stream. The instruction presented is the one supplied for that warp's current PC.
- R4: An instruction whose opcode field (bits 31:28) is 0, or any value not listed below, issues in one beat with turn 0 and the warp's full active mask. The warp's PC then advances by one.
- R5: Opcode 1 (load/store) issues in 4 consecutive beats from the same warp with turns 0,1,2,3. Turn t carries only mask bits [8t+7:8t], and no other warp issues in between.
- R6: After the last load/store turn, the warp issues nothing until `mem_done` is pulsed with `mem_warp` equal to its id. Other eligible warps keep issuing meanwhile.
- R7: Opcode 2 (branch, target PC in bits 7:0) with at least one enabled lane whose condition bit is set narrows the mask to those lanes. It saves (target, old mask) on the warp's stack and continues at PC+1. When the warp's next PC equals the saved target, the saved mask is restored.
- R8: Opcode 2 with no enabled lane whose condition bit is set jumps straight to the target PC and leaves the mask unchanged.
- R9: Opcode 3 (loop back-edge, target in bits 7:0) keeps only enabled lanes whose condition bit is set. If any remain, it jumps to the target with that mask. Otherwise it falls through to PC+1, where the reconvergence rule of R7 applies.
- R10: Opcode 4 (exit) removes the lanes whose condition bit is set. A warp left with no lanes is retired and never issues again. Every non-load/store beat carries a non-zero mask.
- R11: While `iss_valid` is high and `iss_ready` is low, warp id, instruction, mask and turn hold steady into the next cycle.
- R12: `iss_valid` is low whenever every warp is retired or waiting on memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_warp | output | 2 | Warp whose instruction is being looked up |
| fetch_pc | output | 8 | PC of that warp |
| fetch_instr | input | 32 | Instruction word at (fetch_warp, fetch_pc) |
| fetch_pred | input | 32 | Per-lane condition bits for that instruction |
| mem_done | input | 1 | Memory completion pulse |
| mem_warp | input | 2 | Warp that the completion belongs to |
| iss_valid | output | 1 | Issue beat offered |
| iss_ready | input | 1 | Downstream accepts the beat |
| iss_warp | output | 2 | Issuing warp id |
| iss_instr | output | 32 | Issued instruction |
| iss_mask | output | 32 | Lanes that execute this beat |
| iss_turn | output | 2 | Dispatch turn index for load/store, else 0 |

## Verification
Each warp runs a distinct program that mixes arithmetic, load/store, a data-dependent branch, a branch with no taken lanes on one warp, a shrinking loop and a partial exit on another. A cycle-accurate model in the bench predicts every beat. Issue-ready is driven at 100, 70 and 40 percent. At full ready the bench tests pure round-robin and turn sequencing; at the lower rates it tests stall holding and whether arbitration is frozen during a stall. Random memory latencies make all warps sleep at once on some cycles, which separates the R12 idle case from mere back-pressure. Arrival of completions in differing orders shows whether R6 wakes only the named warp.

// File: rtl/simt_pkg.sv
package simt_pkg;
  localparam int INSTR_W = 32;
  localparam int OP_MSB  = 31;
  localparam int OP_LSB  = 28;

  typedef enum logic [3:0] {
    OP_ALU  = 4'd0,
    OP_MEM  = 4'd1,
    OP_BR   = 4'd2,
    OP_LOOP = 4'd3,
    OP_EXIT = 4'd4
  } op_e;
endpackage

// File: rtl/simt_rr_pick.sv
module simt_rr_pick #(
  parameter int N  = 4,
  parameter int WW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [WW-1:0] last,
  output logic [WW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = 1; i <= N; i++) begin
      int c;
      c = (int'(last) + i) % N;
      if (!any && req[c]) begin
        any = 1'b1;
        idx = WW'(c);
      end
    end
  end
endmodule

// File: rtl/simt_warp_ctx.sv
module simt_warp_ctx
  import simt_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int PC_W      = 8,
  parameter int STK_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  op_e              op,
  input  logic [PC_W-1:0]  tgt,
  input  logic [LANES-1:0] pred,
  input  logic             set_wait,
  input  logic             clr_wait,
  output logic [PC_W-1:0]  pc_o,
  output logic [LANES-1:0] mask_o,
  output logic             active_o,
  output logic             waiting_o
);
  localparam int SPW = $clog2(STK_DEPTH + 1);
  localparam int IW  = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1;

  logic [PC_W-1:0]  pc_q;
  logic [LANES-1:0] mask_q;
  logic             act_q, wait_q;
  logic [SPW-1:0]   sp_q;
  logic [PC_W-1:0]  stk_pc [STK_DEPTH];
  logic [LANES-1:0] stk_m  [STK_DEPTH];

  logic [LANES-1:0] taken, nmask;
  logic [PC_W-1:0]  npc, top_pc;
  logic [LANES-1:0] top_m;
  logic             push, may_pop, pop, retire, has_room;
  logic [IW-1:0]    top_i;

  assign has_room = sp_q < SPW'(STK_DEPTH);
  assign top_i    = IW'(sp_q - SPW'(1));
  assign top_pc   = (sp_q != '0) ? stk_pc[top_i] : '0;
  assign top_m    = (sp_q != '0) ? stk_m[top_i]  : '0;

  always_comb begin
    taken   = mask_q & pred;
    npc     = pc_q + PC_W'(1);
    nmask   = mask_q;
    push    = 1'b0;
    may_pop = 1'b1;
    retire  = 1'b0;
    case (op)
      OP_BR: begin
        if (taken == '0) npc = tgt;
        else begin
          nmask   = taken;
          push    = 1'b1;
          may_pop = 1'b0;
        end
      end
      OP_LOOP: begin
        if (taken != '0) begin
          npc   = tgt;
          nmask = taken;
        end
      end
      OP_EXIT: begin
        nmask  = mask_q & ~pred;
        retire = (nmask == '0);
      end
      default: ;
    endcase
    pop = may_pop && (sp_q != '0) && (npc == top_pc);
    if (pop) nmask = top_m;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      mask_q <= '1;
      act_q  <= 1'b1;
      wait_q <= 1'b0;
      sp_q   <= '0;
    end else begin
      if (adv) begin
        pc_q   <= npc;
        mask_q <= nmask;
        if (retire) act_q <= 1'b0;
        if (push && has_room) sp_q <= sp_q + SPW'(1);
        else if (pop)         sp_q <= sp_q - SPW'(1);
      end
      if (set_wait)      wait_q <= 1'b1;
      else if (clr_wait) wait_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && push && has_room) begin
      stk_pc[IW'(sp_q)] <= tgt;
      stk_m[IW'(sp_q)]  <= mask_q;
    end
  end

  assign pc_o      = pc_q;
  assign mask_o    = mask_q;
  assign active_o  = act_q;
  assign waiting_o = wait_q;
endmodule

// File: rtl/simt_issue_sched.sv
module simt_issue_sched
  import simt_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int LANES     = 32,
  parameter int PC_W      = 8,
  parameter int STK_DEPTH = 4,
  parameter int LS_TURNS  = 4,
  localparam int WW       = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int TW       = (LS_TURNS > 1) ? $clog2(LS_TURNS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [WW-1:0]      fetch_warp,
  output logic [PC_W-1:0]    fetch_pc,
  input  logic [INSTR_W-1:0] fetch_instr,
  input  logic [LANES-1:0]   fetch_pred,
  input  logic               mem_done,
  input  logic [WW-1:0]      mem_warp,
  output logic               iss_valid,
  input  logic               iss_ready,
  output logic [WW-1:0]      iss_warp,
  output logic [INSTR_W-1:0] iss_instr,
  output logic [LANES-1:0]   iss_mask,
  output logic [TW-1:0]      iss_turn
);
  localparam int SLICE = LANES / LS_TURNS;
  localparam logic [LANES-1:0] SLICE0 = LANES'({SLICE{1'b1}});

  logic [PC_W-1:0]  pc_a   [NUM_WARPS];
  logic [LANES-1:0] mask_a [NUM_WARPS];
  logic [NUM_WARPS-1:0] act_v, wait_v, elig, adv_v, setw_v, clrw_v;

  logic [WW-1:0] last_q, pick, sel, lock_w, hold_w;
  logic          any_elig, lock_q, hold_q, fire, is_mem, last_turn;
  logic [TW-1:0] turn_q;
  op_e           cur_op;

  assign cur_op    = op_e'(fetch_instr[OP_MSB:OP_LSB]);
  assign is_mem    = (cur_op == OP_MEM);
  assign last_turn = (turn_q == TW'(LS_TURNS - 1));
  assign elig      = act_v & ~wait_v;

  simt_rr_pick #(.N(NUM_WARPS), .WW(WW)) u_pick (
    .req(elig), .last(last_q), .idx(pick), .any(any_elig)
  );

  assign sel       = hold_q ? hold_w : (lock_q ? lock_w : pick);
  assign iss_valid = hold_q | lock_q | any_elig;
  assign fire      = iss_valid & iss_ready;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    assign adv_v[w]  = fire && (sel == WW'(w)) && (!is_mem || last_turn);
    assign setw_v[w] = adv_v[w] && is_mem;
    assign clrw_v[w] = mem_done && (mem_warp == WW'(w));
    simt_warp_ctx #(.LANES(LANES), .PC_W(PC_W), .STK_DEPTH(STK_DEPTH)) u_ctx (
      .clk(clk), .rst_n(rst_n), .adv(adv_v[w]), .op(cur_op),
      .tgt(fetch_instr[PC_W-1:0]), .pred(fetch_pred),
      .set_wait(setw_v[w]), .clr_wait(clrw_v[w]),
      .pc_o(pc_a[w]), .mask_o(mask_a[w]),
      .active_o(act_v[w]), .waiting_o(wait_v[w])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= WW'(NUM_WARPS - 1);
      turn_q <= '0;
      lock_q <= 1'b0;
      lock_w <= '0;
      hold_q <= 1'b0;
      hold_w <= '0;
    end else begin
      hold_q <= iss_valid && !iss_ready;
      hold_w <= sel;
      if (fire) begin
        last_q <= sel;
        if (is_mem) begin
          turn_q <= last_turn ? '0 : turn_q + TW'(1);
          lock_q <= !last_turn;
          lock_w <= sel;
        end
      end
    end
  end

  assign fetch_warp = sel;
  assign fetch_pc   = pc_a[sel];
  assign iss_warp   = sel;
  assign iss_instr  = fetch_instr;
  assign iss_turn   = is_mem ? turn_q : '0;
  assign iss_mask   = is_mem ? (mask_a[sel] & (SLICE0 << (int'(turn_q) * SLICE)))
                             : mask_a[sel];
endmodule

// File: rtl/simt_issue_chk.sv
module simt_issue_chk
  import simt_pkg::*;
#(
  parameter int LANES    = 32,
  parameter int WW       = 2,
  parameter int TW       = 2,
  parameter int LS_TURNS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               iss_valid,
  input logic               iss_ready,
  input logic [WW-1:0]      iss_warp,
  input logic [INSTR_W-1:0] iss_instr,
  input logic [LANES-1:0]   iss_mask,
  input logic [TW-1:0]      iss_turn
);
  logic beat_mem, fire;
  assign beat_mem = iss_valid && (iss_instr[OP_MSB:OP_LSB] == OP_MEM);
  assign fire     = iss_valid && iss_ready;

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_warp) && $stable(iss_instr)
      && $stable(iss_mask) && $stable(iss_turn));

  // R5
  turn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && beat_mem && iss_turn != TW'(LS_TURNS - 1) |=>
      iss_valid && iss_warp == $past(iss_warp) && iss_turn == TW'($past(iss_turn) + 1'b1));

  // R6
  mem_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && beat_mem && iss_turn == TW'(LS_TURNS - 1) |=>
      !(iss_valid && iss_warp == $past(iss_warp)));

  // R10
  live_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !beat_mem |-> iss_mask != '0);

  // R4
  single_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !beat_mem |-> iss_turn == '0);
endmodule

bind simt_issue_sched simt_issue_chk #(
  .LANES(LANES), .WW(WW), .TW(TW), .LS_TURNS(LS_TURNS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_warp(iss_warp), .iss_instr(iss_instr), .iss_mask(iss_mask), .iss_turn(iss_turn)
);

// File: tb/sim_simt_issue_sched.sv
module sim_simt_issue_sched;
  localparam int NW = 4, LN = 32, DP = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  fetch_warp, mem_warp = '0, iss_warp, iss_turn;
  logic [7:0]  fetch_pc;
  logic [31:0] fetch_instr, fetch_pred, iss_instr, iss_mask;
  logic        mem_done = 1'b0, iss_valid, iss_ready = 1'b0;
  int          seed = 0;
  int          total = 0, bad = 0;

  simt_issue_sched u0 (
    .clk(clk), .rst_n(rst_n), .fetch_warp(fetch_warp), .fetch_pc(fetch_pc),
    .fetch_instr(fetch_instr), .fetch_pred(fetch_pred), .mem_done(mem_done),
    .mem_warp(mem_warp), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_warp(iss_warp), .iss_instr(iss_instr), .iss_mask(iss_mask), .iss_turn(iss_turn)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] mk(int op, int tgt, int w, int pc);
    return {4'(op), 4'(w), 16'h0, (op == 2 || op == 3) ? 8'(tgt) : 8'(pc)};
  endfunction

  function automatic logic [31:0] prog(int w, int pc);
    case (pc)
      1, 4:    return mk(1, 0, w, pc);
      2:       return mk(2, 6, w, pc);
      7:       return mk(2, 11, w, pc);
      8:       return mk((w == 3) ? 1 : 0, 0, w, pc);
      11:      return mk(2, 14, w, pc);
      13:      return mk(3, 12, w, pc);
      15, 17:  return mk(4, 0, w, pc);
      default: return mk(0, 0, w, pc);
    endcase
  endfunction

  function automatic logic [31:0] hsh(int a, int b);
    logic [31:0] x;
    x = (32'(a) * 32'h9E3779B9) ^ (32'(b) * 32'h85EBCA6B);
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    return x ^ (x >> 12);
  endfunction

  function automatic logic [31:0] pred_fn(int w, int pc, logic [31:0] m, int s);
    logic [31:0] lo;
    lo = m & (~m + 32'd1);
    case (pc)
      2:       return hsh(w, pc + s);
      7:       return (w == 2) ? 32'h0 : hsh(w, 7 + s);
      11, 17:  return '1;
      13:      return hsh(w, int'(m) ^ s) & m & ~lo;
      15:      return (w == 1) ? 32'h0000FFFF : '1;
      default: return '0;
    endcase
  endfunction

  always_comb begin
    fetch_instr = prog(int'(fetch_warp), int'(fetch_pc));
    fetch_pred  = pred_fn(int'(fetch_warp), int'(fetch_pc), iss_mask, seed);
  end

  // reference model state
  int          m_pc [NW], m_sp [NW], m_note [NW], m_cnt [NW];
  logic [31:0] m_mask [NW], s_mask [NW][DP];
  int          s_rpc [NW][DP];
  bit          m_act [NW], m_wait [NW];
  int          m_last, m_turn, m_lockw, m_holdw;
  bit          m_lock, m_hold;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string mtag(int op, int note);
    if (op == 1) return "R5";
    if (op == 2) return "R7";
    if (op == 3) return "R9";
    if (op == 4) return "R10";
    if (note == 8) return "R8";
    if (note == 7) return "R7";
    return "R4";
  endfunction

  task automatic m_reset();
    for (int w = 0; w < NW; w++) begin
      m_pc[w] = 0; m_sp[w] = 0; m_note[w] = 0; m_cnt[w] = -1;
      m_mask[w] = '1; m_act[w] = 1; m_wait[w] = 0;
    end
    m_last = NW - 1; m_turn = 0; m_lock = 0; m_hold = 0; m_lockw = 0; m_holdw = 0;
  endtask

  task automatic m_advance(int w, int op, int tgt, logic [31:0] pr);
    logic [31:0] m, tk, nm;
    int npc, note;
    bit push, maypop;
    m = m_mask[w]; tk = m & pr; npc = m_pc[w] + 1; nm = m;
    push = 0; maypop = 1; note = 0;
    case (op)
      2: if (tk == 0) begin npc = tgt; note = 8; end
         else begin nm = tk; push = 1; maypop = 0; end
      3: if (tk != 0) begin npc = tgt; nm = tk; end
      4: begin nm = m & ~pr; if (nm == 0) m_act[w] = 0; end
      default: ;
    endcase
    if (maypop && m_sp[w] > 0 && npc == s_rpc[w][m_sp[w]-1]) begin
      nm = s_mask[w][m_sp[w]-1]; m_sp[w]--; note = 7;
    end
    if (push && m_sp[w] < DP) begin
      s_rpc[w][m_sp[w]] = tgt; s_mask[w][m_sp[w]] = m; m_sp[w]++;
    end
    m_pc[w] = npc & 8'hFF; m_mask[w] = nm; m_note[w] = note;
  endtask

  task automatic m_pick(output bit v, output int w);
    v = 0; w = 0;
    if (m_hold) begin v = 1; w = m_holdw; end
    else if (m_lock) begin v = 1; w = m_lockw; end
    else
      for (int i = 1; i <= NW; i++) begin
        int c;
        c = (m_last + i) % NW;
        if (!v && m_act[c] && !m_wait[c]) begin v = 1; w = c; end
      end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; iss_ready = 1'b0; mem_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_reset();
    #1;
    // R1: reset state
    chk(iss_valid && iss_warp == 0 && fetch_pc == 0 && iss_mask == '1 && iss_turn == 0,
        "R1 reset", {iss_valid, iss_warp, fetch_pc, iss_mask}, {1'b1, 2'd0, 8'd0, 32'hFFFFFFFF});
  endtask

  task automatic run(int s, int rdy_pct);
    int cyc;
    bit alive, pstall;
    logic [1:0] pw, pt;
    logic [31:0] pm, pi;
    seed = s;
    do_reset();
    cyc = 0; pstall = 0; pw = 0; pt = 0; pm = 0; pi = 0;
    alive = 1;
    while (alive && cyc < 20000) begin
      bit ev, hs, md;
      int ew, op, mw;
      logic [31:0] ins, pr, em;
      if (cyc > 0) @(negedge clk);
      cyc++;
      m_pick(ev, ew);
      if (pstall)  // R11 held beat
        chk(iss_valid && iss_warp == pw && iss_mask == pm && iss_turn == pt && iss_instr == pi,
            "R11 stall hold", {iss_warp, iss_turn, iss_mask}, {pw, pt, pm});
      if (!ev) begin
        chk(!iss_valid, "R12 idle", 64'(iss_valid), 64'(0));
        op = 0; ins = 0; pr = 0;
      end else begin
        ins = prog(ew, m_pc[ew]);
        op  = int'(ins[31:28]);
        pr  = pred_fn(ew, m_pc[ew], m_mask[ew], s);
        em  = (op == 1) ? (m_mask[ew] & (32'hFF << (8 * m_turn))) : m_mask[ew];
        chk(iss_valid && iss_warp == 2'(ew), "R2 R6 pick", {iss_valid, iss_warp}, {1'b1, 2'(ew)});
        chk(iss_instr == ins, "R3 order", 64'(iss_instr), 64'(ins));
        chk(iss_mask == em && iss_turn == ((op == 1) ? 2'(m_turn) : 2'd0),
            mtag(op, m_note[ew]), {iss_turn, iss_mask}, {(op == 1) ? 2'(m_turn) : 2'd0, em});
      end
      // drive inputs for the next edge
      iss_ready = ($urandom % 100) < rdy_pct;
      md = 0; mw = 0;
      for (int w = 0; w < NW; w++)
        if (!md && m_wait[w] && m_cnt[w] == 0) begin md = 1; mw = w; end
      for (int w = 0; w < NW; w++) if (m_cnt[w] > 0) m_cnt[w]--;
      mem_done = md; mem_warp = 2'(mw);
      // model update for that edge
      hs = ev && iss_ready;
      pstall = ev && !iss_ready;
      pw = iss_warp; pt = iss_turn; pm = iss_mask; pi = iss_instr;
      m_hold = pstall; m_holdw = ew;
      if (hs) begin
        m_last = ew;
        if (op == 1) begin
          if (m_turn < 3) begin m_turn++; m_lock = 1; m_lockw = ew; end
          else begin
            m_turn = 0; m_lock = 0; m_wait[ew] = 1;
            m_cnt[ew] = 1 + int'($urandom % 12);
            m_advance(ew, 0, 0, 0);
          end
        end else m_advance(ew, op, int'(ins[7:0]), pr);
      end
      if (md) begin m_wait[mw] = 0; m_cnt[mw] = -1; end
      alive = 0;
      for (int w = 0; w < NW; w++) if (m_act[w]) alive = 1;
    end
    if (cyc >= 20000) chk(0, "watchdog", 64'(cyc), 64'(0));
    repeat (2) begin
      @(negedge clk);
      iss_ready = 1'b1; mem_done = 1'b0;
      // R10 all retired, R12 nothing offered
      chk(!iss_valid, "R10 R12 retired", 64'(iss_valid), 64'(0));
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    m_reset();
    run(11, 100);
    run(257, 70);
    run(4099, 40);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule